// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 32-bit RISC-style core fetches next. The decode stage gives it the major opcode, the funct3 field, the destination register index, a sign-extended immediate and the two source operand values. The block settles conditional branches, the PC-relative jump and the register-indirect jump. It returns the next program counter, a link value with its write enable for the destination register, and a flag for a misaligned indirect-jump target.

The current program counter is held in a register inside the block. A synchronous reset loads that register with a parameterised vector. A step strobe moves it to the computed next value. A flagged misaligned target blocks the move, so the trap logic outside can take over. Fetch, the register file and trap vectoring are outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC register is loaded with `RESET_VEC`. `pc` shows that value in the cycle that follows.
- R2: Opcode 1100011 is a conditional branch. funct3 000 is taken when the operands are equal, 001 when they differ, 100 when `rs1_val` is less than `rs2_val` as signed numbers, and 110 when it is less as unsigned numbers. A taken branch gives `next_pc = pc + imm`, and a branch that is not taken gives `pc + 4`.
- R3: For a branch, funct3 101 is taken exactly when 100 would not be, and 111 is taken exactly when 110 would not be.
- R4: A branch with funct3 010 or 011 is never taken, so `next_pc = pc + 4`.
- R5: Opcode 1101111 gives `next_pc = pc + imm` and `link_val = pc + 4`. `link_we` is high only when `rd_idx` is not 0.
- R6: Opcode 1100111 with funct3 000 forms a target `rs1_val + imm`. When bit 1 of the target is clear, `next_pc` is the target with bit 0 forced to 0, `link_val = pc + 4`, and `link_we` is high only when `rd_idx` is not 0.
- R7: When bit 1 of that indirect target is set, `misalign` is high, `link_we` is low and `next_pc` equals `pc`. A step in that cycle leaves the PC register unchanged.
- R8: Any other opcode, and opcode 1100111 with a funct3 other than 000, gives `next_pc = pc + 4`. In that case `link_we` and `misalign` are both low.
- R9: The PC register loads `next_pc` at a rising edge only when `step` is high. Without `step` it holds its value.
- R10: `link_we` is never high while `rd_idx` is 0. `misalign` is never high for an opcode other than 1100111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance the PC register this cycle |
| opcode | input | 7 | Major opcode of the current instruction |
| funct3 | input | 3 | Minor function field |
| rd_idx | input | 5 | Destination register index |
| imm | input | XLEN | Sign-extended immediate |
| rs1_val | input | XLEN | First source operand value |
| rs2_val | input | XLEN | Second source operand value |
| pc | output | XLEN | Current PC register |
| next_pc | output | XLEN | Computed next PC |
| link_val | output | XLEN | Return address, PC plus 4 |
| link_we | output | 1 | Write enable for the link value |
| misalign | output | 1 | Indirect-jump target has bit 1 set |

## Verification
The bench builds the block with XLEN 32 and a reset vector of 0xFFFFFFF0. With that vector, a few sequential steps carry the PC across the 32-bit wrap, so the carry out of the PC+4 and PC+imm adders is exercised. Operand pairs are chosen so that they straddle the sign boundary: the signed and unsigned comparisons disagree on them, and the complement conditions can be told apart. Indirect targets are formed with every value of the two low bits.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam logic [6:0] OPC_COND_BR  = 7'b1100011;
    localparam logic [6:0] OPC_REL_JUMP = 7'b1101111;
    localparam logic [6:0] OPC_REG_JUMP = 7'b1100111;

    localparam logic [2:0] CMP_EQ  = 3'b000;
    localparam logic [2:0] CMP_NE  = 3'b001;
    localparam logic [2:0] CMP_LT  = 3'b100;
    localparam logic [2:0] CMP_GE  = 3'b101;
    localparam logic [2:0] CMP_LTU = 3'b110;
    localparam logic [2:0] CMP_GEU = 3'b111;

    typedef enum logic [1:0] {
        FLOW_SEQ,
        FLOW_COND,
        FLOW_REL,
        FLOW_REG
    } flow_kind_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [2:0]   cond_sel,
    output logic         taken
);
    logic is_eq;
    logic is_lt_s;
    logic is_lt_u;

    always_comb begin
        is_eq   = (lhs == rhs);
        is_lt_s = ($signed(lhs) < $signed(rhs));
        is_lt_u = (lhs < rhs);
        unique case (cond_sel)
            CMP_EQ:  taken = is_eq;
            CMP_NE:  taken = !is_eq;
            CMP_LT:  taken = is_lt_s;
            CMP_GE:  taken = !is_lt_s;
            CMP_LTU: taken = is_lt_u;
            CMP_GEU: taken = !is_lt_u;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_adders.sv
module npc_adders #(
    parameter int W         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [W-1:0] cur_pc,
    input  logic [W-1:0] offset,
    input  logic [W-1:0] base,
    output logic [W-1:0] seq_pc,
    output logic [W-1:0] rel_pc,
    output logic [W-1:0] reg_pc
);
    localparam logic [W-1:0] STEP_BYTES = W'(INSN_BYTES);

    always_comb begin
        seq_pc = cur_pc + STEP_BYTES;
        rel_pc = cur_pc + offset;
        reg_pc = base + offset;
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic [4:0]      rd_idx,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] link_val,
    output logic            link_we,
    output logic            misalign
);
    localparam logic [XLEN-1:0] BOOT_PC = XLEN'(RESET_VEC);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } npc_state_t;

    npc_state_t st_d, st_q;
    flow_kind_e kind_d;

    logic            br_taken_d;
    logic [XLEN-1:0] seq_pc_d, rel_pc_d, reg_pc_d;
    logic            rd_live_d;

    npc_cond #(.W(XLEN)) u_cond (
        .lhs      (rs1_val),
        .rhs      (rs2_val),
        .cond_sel (funct3),
        .taken    (br_taken_d)
    );

    npc_adders #(.W(XLEN), .INSN_BYTES(4)) u_add (
        .cur_pc (st_q.pc),
        .offset (imm),
        .base   (rs1_val),
        .seq_pc (seq_pc_d),
        .rel_pc (rel_pc_d),
        .reg_pc (reg_pc_d)
    );

    always_comb begin
        rd_live_d = (rd_idx != 5'd0);
        if (opcode == OPC_COND_BR)
            kind_d = FLOW_COND;
        else if (opcode == OPC_REL_JUMP)
            kind_d = FLOW_REL;
        else if (opcode == OPC_REG_JUMP && funct3 == 3'b000)
            kind_d = FLOW_REG;
        else
            kind_d = FLOW_SEQ;

        next_pc  = seq_pc_d;
        link_val = seq_pc_d;
        link_we  = 1'b0;
        misalign = 1'b0;
        unique case (kind_d)
            FLOW_COND: next_pc = br_taken_d ? rel_pc_d : seq_pc_d;
            FLOW_REL: begin
                next_pc = rel_pc_d;
                link_we = rd_live_d;
            end
            FLOW_REG: begin
                if (reg_pc_d[1]) begin
                    misalign = 1'b1;
                    next_pc  = st_q.pc;
                end else begin
                    next_pc = {reg_pc_d[XLEN-1:1], 1'b0};
                    link_we = rd_live_d;
                end
            end
            default: next_pc = seq_pc_d;
        endcase

        st_d = st_q;
        if (rst)
            st_d.pc = BOOT_PC;
        else if (step && !misalign)
            st_d.pc = next_pc;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc = st_q.pc;

    AST_RESET_LOADS_VEC: assert property (@(posedge clk) rst |=> pc == BOOT_PC); // R1
    AST_FAULT_BLOCKS_LINK: assert property (@(posedge clk) disable iff (rst)
        misalign |-> !link_we && next_pc == pc); // R7
    AST_FAULT_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        (step && misalign) |=> $stable(pc)); // R7
    AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc)); // R9
    AST_X0_NEVER_LINKED: assert property (@(posedge clk) disable iff (rst)
        rd_idx == 5'd0 |-> !link_we); // R10
    AST_FAULT_ONLY_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
        misalign |-> opcode == OPC_REG_JUMP); // R10
    AST_REG_TARGET_EVEN: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_REG_JUMP && funct3 == 3'b000 && !misalign) |-> !next_pc[0]); // R6

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VEC        = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst, step;
    logic [6:0]  opcode;
    logic [2:0]  funct3;
    logic [4:0]  rd_idx;
    logic [31:0] imm, rs1_val, rs2_val;
    logic [31:0] pc, next_pc, link_val;
    logic        link_we, misalign;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] model_pc;

    npc_unit #(.XLEN(32), .RESET_VEC(VEC)) uut (
        .clk, .rst, .step, .opcode, .funct3, .rd_idx, .imm,
        .rs1_val, .rs2_val, .pc, .next_pc, .link_val, .link_we, .misalign
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cmp(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // reference: returns expected next pc, link enable, fault flag
    task automatic ref_model(input logic [6:0] op, input logic [2:0] f3, input logic [4:0] rd,
                             input logic [31:0] im, input logic [31:0] a, input logic [31:0] b,
                             output logic [31:0] npc, output logic lwe, output logic flt,
                             output string req);
        logic [31:0] tgt;
        bit tk;
        npc = model_pc + 32'd4; lwe = 1'b0; flt = 1'b0; req = "R8";
        if (op == 7'b1100011) begin
            case (f3)
                3'b000: begin tk = (a == b); req = "R2"; end
                3'b001: begin tk = (a != b); req = "R2"; end
                3'b100: begin tk = ($signed(a) < $signed(b)); req = "R2"; end
                3'b110: begin tk = (a < b); req = "R2"; end
                3'b101: begin tk = !($signed(a) < $signed(b)); req = "R3"; end
                3'b111: begin tk = !(a < b); req = "R3"; end
                default: begin tk = 0; req = "R4"; end
            endcase
            if (tk) npc = model_pc + im;
        end else if (op == 7'b1101111) begin
            npc = model_pc + im; lwe = (rd != 0); req = "R5";
        end else if (op == 7'b1100111 && f3 == 3'b000) begin
            tgt = a + im;
            if (tgt[1]) begin
                flt = 1'b1; npc = model_pc; req = "R7";
            end else begin
                npc = tgt & 32'hFFFF_FFFE; lwe = (rd != 0); req = "R6";
            end
        end
    endtask

    task automatic apply(input logic [6:0] op, input logic [2:0] f3, input logic [4:0] rd,
                         input logic [31:0] im, input logic [31:0] a, input logic [31:0] b,
                         input logic stp);
        logic [31:0] e_npc;
        logic e_we, e_flt;
        string req;
        @(negedge clk);
        opcode = op; funct3 = f3; rd_idx = rd; imm = im; rs1_val = a; rs2_val = b; step = stp;
        #1;
        ref_model(op, f3, rd, im, a, b, e_npc, e_we, e_flt, req);
        cmp("R9", "pc", pc, model_pc);
        cmp(req, "next_pc", next_pc, e_npc);
        cmp(req, "link_we", {31'd0, link_we}, {31'd0, e_we});
        cmp(req, "misalign", {31'd0, misalign}, {31'd0, e_flt});
        if (e_we) cmp(req, "link_val", link_val, model_pc + 32'd4);
        if (rd == 0) cmp("R10", "link_we_x0", {31'd0, link_we}, 32'd0);
        @(posedge clk);
        if (stp && !e_flt) model_pc = e_npc;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; step = 1'b0; opcode = 7'd0; funct3 = 3'd0; rd_idx = 5'd0;
        imm = 32'd0; rs1_val = 32'd0; rs2_val = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_pc = VEC;
        cmp("R1", "reset pc", pc, VEC);
        // sequential steps across the 32-bit wrap (R8)
        for (int i = 0; i < 6; i++) apply(7'b0010011, 3'b000, 5'd1, 32'd0, 32'd0, 32'd0, 1'b1);
        // R9: no step, pc holds
        apply(7'b1101111, 3'b000, 5'd1, 32'h100, 0, 0, 1'b0);
        apply(7'b0110011, 3'b000, 5'd1, 32'h0, 0, 0, 1'b0);
        // R2/R3/R4 with sign-straddling operands
        for (int f = 0; f < 8; f++) begin
            apply(7'b1100011, 3'(f), 5'd0, 32'h40, 32'h8000_0000, 32'h0000_0001, 1'b1);
            apply(7'b1100011, 3'(f), 5'd0, 32'hFFFF_FFC0, 32'h0000_0001, 32'h8000_0000, 1'b1);
            apply(7'b1100011, 3'(f), 5'd0, 32'h10, 32'h1234_5678, 32'h1234_5678, 1'b1);
        end
        // R5 with rd zero and nonzero
        apply(7'b1101111, 3'b000, 5'd0, 32'h800, 0, 0, 1'b1);
        apply(7'b1101111, 3'b011, 5'd31, 32'hFFFF_F000, 0, 0, 1'b1);
        // R6/R7: every combination of the two low target bits
        for (int lo = 0; lo < 4; lo++) begin
            apply(7'b1100111, 3'b000, 5'd5, 32'h0000_0010, 32'h0000_2000 | 32'(lo), 0, 1'b1);
            apply(7'b1100111, 3'b000, 5'd0, 32'hFFFF_FFFF, 32'h0000_3000 | 32'(lo), 0, 1'b1);
        end
        // R8: indirect-jump opcode with nonzero funct3
        apply(7'b1100111, 3'b001, 5'd4, 32'h2, 32'h2, 0, 1'b1);
        // R7 with no step, then with step
        apply(7'b1100111, 3'b000, 5'd3, 32'h0, 32'h0000_0002, 0, 1'b0);
        apply(7'b1100111, 3'b000, 5'd3, 32'h0, 32'h0000_0002, 0, 1'b1);
        // mixed stream
        for (int k = 0; k < 400; k++) begin
            logic [6:0] op;
            logic [31:0] a, b;
            case ($urandom % 5)
                0: op = 7'b1100011;
                1: op = 7'b1101111;
                2: op = 7'b1100111;
                3: op = 7'b0110011;
                default: op = 7'b1100011;
            endcase
            a = $urandom; b = ($urandom % 3 == 0) ? a : $urandom;
            apply(op, 3'($urandom), 5'($urandom), {{20{1'b0}}, 12'($urandom)} ^ (($urandom % 2) ? 32'hFFFF_F000 : 32'h0),
                  a, b, 1'($urandom % 4 != 0));
        end
        // R1: reset mid-run
        @(negedge clk); rst = 1'b1; step = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0; step = 1'b0;
        model_pc = VEC;
        cmp("R1", "pc after reset", pc, VEC);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule